// File: doc/BRIEF.md
# Line-Interface Off-Hook and Status Controller

This block is the digital control core of a telephone-line interface. It works out whether the line is seized (off-hook) from two sources: a software control bit, and an active-low hook pin that only counts once its own enable bit is set. After the line goes off-hook, the block counts sample-rate strobes. It flags received line data as valid only after a fixed settling count, which covers the front-end filter group delay.

Two sticky status flags report line trouble. One records a billing tone strong enough to corrupt data, and it is armed only while its enable bit is set. The other records overdrive of the receive input. Each flag stays set until software writes zero to it. The block also decodes two strap pins into a serial-port mode and reports the reserved code as an error. A small register port with an address, write strobe and combinational read gives software access to the control, enable and status registers.

Top module: `line_hook_ctrl`

## Requirements
- R1: After reset the line is on-hook, data-valid is low, and the control (address 5), tone-enable (address 16) and status (address 17) registers all read 0.
- R2: The line is off-hook whenever control bit 0 is 1, or whenever control bit 1 is 1 and the hook pin is 0.
- R3: When control bit 1 is 0, the hook pin has no effect on the off-hook output.
- R4: Data-valid rises in the clock after the 4620th sample strobe received while off-hook (parameter SETTLE). Clock cycles without a strobe do not advance the count.
- R5: A return to on-hook drops data-valid in the same cycle and restarts the count from zero, so the next off-hook period again needs the full count.
- R6: A billing-tone strobe sets status bit 0 only while tone-enable bit 0 (address 16) is 1. Otherwise the strobe is ignored.
- R7: An overdrive strobe sets status bit 1 at any time.
- R8: A write to address 17 clears each status bit whose write-data bit is 0 and leaves set each bit whose write-data bit is 1. No other event clears the flags.
- R9: When a detect strobe and a clearing write to the same flag occur in the same cycle, the flag ends up set.
- R10: Mode pins 00, 01 and 10 appear unchanged on the serial-mode output with mode error low. Code 11 gives mode error high and serial mode 00.
- R11: Reads are combinational on the address. Address 5 returns {6'b0, pin enable, hook bit}, address 16 returns {7'b0, tone enable}, address 17 returns {6'b0, overdrive, billing}, and every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hook_pin_n | input | 1 | Off-hook request pin, active low, synchronous to clk |
| smp_stb | input | 1 | One pulse per sample period |
| bill_det_stb | input | 1 | Billing-tone detector hit |
| rx_ovr_stb | input | 1 | Receive-input overdrive hit |
| mode_pins | input | 2 | Serial-mode strap pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| offhook | output | 1 | Effective off-hook state |
| rx_valid | output | 1 | Received line data valid |
| ser_mode | output | 2 | Decoded serial mode |
| mode_err | output | 1 | Reserved mode selected |

## Verification
The hardest case to reach from the ports is the settling boundary and its restart. Data-valid has to stay low after exactly one strobe fewer than the count and rise after the last one. A short off-hook burst interrupted by on-hook must leave no partial count behind. The stimulus issues precisely counted strobes with idle clocks between them, checks at both sides of the boundary, and then repeats the full count after an interrupted attempt. The set-versus-clear race is produced by raising the detect strobe in the same cycle as a zero write to the status register.

// File: rtl/line_hook_ctrl.sv
module line_hook_ctrl #(
  parameter int SETTLE    = 4620,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int ADDR_CTRL = 5,
  parameter int ADDR_TONE = 16,
  parameter int ADDR_STAT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hook_pin_n,
  input  logic          smp_stb,
  input  logic          bill_det_stb,
  input  logic          rx_ovr_stb,
  input  logic [1:0]    mode_pins,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          offhook,
  output logic          rx_valid,
  output logic [1:0]    ser_mode,
  output logic          mode_err
);

  localparam int CW = $clog2(SETTLE + 1);

  logic          hook_req, pin_en, tone_en, bill_flag, ovr_flag, valid_q;
  logic [CW-1:0] cnt;

  wire wr_ctrl = reg_we && (reg_addr == AW'(ADDR_CTRL));
  wire wr_tone = reg_we && (reg_addr == AW'(ADDR_TONE));
  wire wr_stat = reg_we && (reg_addr == AW'(ADDR_STAT));

  assign offhook  = hook_req | (pin_en & ~hook_pin_n);
  assign rx_valid = valid_q & offhook;
  assign mode_err = &mode_pins;
  assign ser_mode = mode_err ? 2'b00 : mode_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hook_req <= 1'b0;
      pin_en   <= 1'b0;
      tone_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        hook_req <= reg_wdata[0];
        pin_en   <= reg_wdata[1];
      end
      if (wr_tone) tone_en <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bill_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      bill_flag <= (bill_det_stb & tone_en) | (bill_flag & ~(wr_stat & ~reg_wdata[0]));
      ovr_flag  <= rx_ovr_stb | (ovr_flag & ~(wr_stat & ~reg_wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else if (!offhook) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else if (smp_stb && !valid_q) begin
      if (cnt == CW'(SETTLE - 1)) valid_q <= 1'b1;
      else                        cnt     <= cnt + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADDR_CTRL))      reg_rdata[1:0] = {pin_en, hook_req};
    else if (reg_addr == AW'(ADDR_TONE)) reg_rdata[0]   = tone_en;
    else if (reg_addr == AW'(ADDR_STAT)) reg_rdata[1:0] = {ovr_flag, bill_flag};
  end

  AST_VALID_NEEDS_HOOK: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> offhook); // R5
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!pin_en && !hook_req) |-> !offhook); // R3
  AST_VALID_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid_q) |-> $past(smp_stb)); // R4
  AST_BILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (bill_flag && !(wr_stat && !reg_wdata[0])) |=> bill_flag); // R8
  AST_BILL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (bill_det_stb && tone_en) |=> bill_flag); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_ovr_stb |=> ovr_flag); // R7
  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n) mode_err |-> (ser_mode == 2'b00)); // R10

endmodule

// File: tb/line_hook_ctrl_test.sv
module line_hook_ctrl_test;
  localparam int SETTLE = 4620;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       hook_pin_n = 1'b1, smp_stb = 1'b0, bill_det_stb = 1'b0, rx_ovr_stb = 1'b0;
  logic [1:0] mode_pins = 2'b00;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       offhook, rx_valid, mode_err;
  logic [1:0] ser_mode;

  always #4 clk = ~clk;

  line_hook_ctrl uut (.*);

  typedef struct { string req; int got; int exp; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input int got, input int exp);
    item_t it;
    it.req = req; it.got = got; it.exp = exp;
    sb_q.push_back(it);
  endtask

  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_cmp++;
      if (it.got != it.exp) begin
        n_bad++;
        $display("FAIL %s got=%0d expected=%0d", it.req, it.got, it.exp);
      end
    end
  end

  task automatic wr(input int a, input int d, input bit bill = 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d); bill_det_stb = bill;
    @(negedge clk);
    reg_we = 1'b0; bill_det_stb = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
    end
  endtask

  task automatic pulse_bill();
    @(negedge clk); bill_det_stb = 1'b1;
    @(negedge clk); bill_det_stb = 1'b0;
  endtask

  task automatic pulse_ovr();
    @(negedge clk); rx_ovr_stb = 1'b1;
    @(negedge clk); rx_ovr_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 offhook", offhook, 0);
    check("R1 rx_valid", rx_valid, 0);
    rd(5, d);  check("R1 ctrl", d, 0);
    rd(16, d); check("R1 tone", d, 0);
    rd(17, d); check("R1 stat", d, 0);

    hook_pin_n = 1'b0;
    @(negedge clk); check("R3 pin ignored", offhook, 0);
    pulse_bill();
    rd(17, d); check("R6 tone disabled", d, 0);

    wr(5, 2);
    @(negedge clk); check("R2 pin low enabled", offhook, 1);
    hook_pin_n = 1'b1;
    @(negedge clk); check("R2 pin high enabled", offhook, 0);
    wr(5, 1);
    @(negedge clk); check("R2 reg bit", offhook, 1);
    rd(5, d); check("R11 ctrl read", d, 1);

    repeat (20) @(negedge clk);
    check("R4 no strobes", rx_valid, 0);
    strobes(SETTLE - 1);
    check("R4 one short", rx_valid, 0);
    strobes(1);
    check("R4 full count", rx_valid, 1);

    wr(5, 0);
    check("R5 drop", rx_valid, 0);
    wr(5, 1);
    strobes(100);
    wr(5, 0);
    wr(5, 1);
    strobes(SETTLE - 1);
    check("R5 restart short", rx_valid, 0);
    strobes(1);
    check("R5 restart full", rx_valid, 1);
    wr(5, 0);

    wr(16, 1);
    rd(16, d); check("R11 tone read", d, 1);
    pulse_bill();
    rd(17, d); check("R6 bill set", d, 1);
    pulse_ovr();
    rd(17, d); check("R7 ovr set", d, 3);
    repeat (5) @(negedge clk);
    rd(17, d); check("R8 sticky", d, 3);
    wr(17, 1);
    rd(17, d); check("R8 partial clear", d, 1);
    wr(17, 0, 1'b1);
    rd(17, d); check("R9 set wins", d, 1);
    wr(17, 0);
    rd(17, d); check("R8 clear", d, 0);
    wr(16, 0);
    pulse_ovr();
    rd(17, d); check("R7 ovr without enable", d, 2);

    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode_pins = 2'(m);
      #1;
      check("R10 mode", int'(ser_mode), (m == 3) ? 0 : m);
      check("R10 err", int'(mode_err), (m == 3) ? 1 : 0);
    end
    rd(3, d); check("R11 unmapped", d, 0);

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule